// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter

This block turns bytes written into a single-entry holding buffer into a bit-serial HDLC line signal, one line bit per clock. It opens frames with a flag, inserts a zero after every five consecutive ones inside data and CRC fields, and accumulates a 16-bit CRC over the data. When the holding buffer and the shift register both run dry in mid-frame, it closes the frame. How it closes depends on a sticky end-of-message latch and on an abort-versus-CRC policy input. Between frames the line carries either continuous flags or continuous ones, and the output can be NRZI coded.

Work is done in units of eight line bits: a flag, a group of eight ones, a data byte, or one CRC byte. Stuffed units may be nine or more bits long. The choice of the next unit is made only in the last cycle of the current one. As a result, mark idle always leaves in whole groups of eight ones, and a frame starting during mark idle never cuts a group short. Two options let software avoid fine timing. The first inserts an opening flag automatically and presets the CRC when a frame begins. The second clears the end-of-message latch automatically at each new frame.

Top module: `hdlc_tx`

## Requirements
- R1: A `wrStrobe` while `bufEmpty` is 1 stores `wrData`, and `bufEmpty` reads 0 from the next cycle. A `wrStrobe` while `bufEmpty` is 0 is ignored. The buffer empties in the cycle after its byte is loaded for transmission.
- R2: One line bit leaves per clock, least significant bit first. A flag is 0x7E, and an abort or mark-idle group is eight ones. A new unit is chosen only after every bit of the current unit, including any stuffed zero, has gone out.
- R3: Inside data and CRC units, a 0 is sent after every fifth consecutive 1, and the run of ones carries across byte boundaries. Flags and groups of ones are never stuffed, and they reset the run.
- R4: After reset the line sends groups of ones. Outside a frame with an empty buffer, each unit is a flag when `idleFlags`=1 and eight ones when `idleFlags`=0. The same applies after a closing flag.
- R5: A byte waiting outside a frame starts one. If the unit just sent was a flag, data follows at once. If it was ones, a flag comes first when `autoOpenFlag`=1, and the data goes out with no flag when `autoOpenFlag`=0.
- R6: The CRC uses the reflected CCITT polynomial 0x8408, fed data LSB first. It absorbs each data byte only when `crcEn`=1. At a frame start with `autoOpenFlag`=1 it is preset to all ones (`crcPresetOnes`=1) or all zeros. Otherwise it keeps its prior value, which is all ones after reset. It is sent complemented, low byte first.
- R7: On an underrun with `txEn`=1, latch clear, `abortOnUnderrun`=0 and `crcEn`=1, the frame ends with CRC low byte, CRC high byte, then a flag. The latch sets in the cycle after the CRC low byte is loaded.
- R8: On an underrun with `txEn`=1, latch clear and `abortOnUnderrun`=1, the frame ends with eight ones then a flag, and the latch sets.
- R9: On an underrun with `txEn`=1 and the latch set, only a closing flag is sent. With the latch clear, `abortOnUnderrun`=0 and `crcEn`=0, only a closing flag is sent and the latch does not change.
- R10: `eomLatch` is 1 after reset. A one-cycle `eomClear` clears it, and so does the start of a frame when `autoEomClear`=1. A set from the transmitter in the same cycle wins over a clear.
- R11: With `txEn`=0 at a unit boundary, the next unit is eight ones. Any frame or ending in progress is dropped without CRC, and a byte in the buffer is kept.
- R12: With `nrziEn`=1, a 0 toggles the line and a 1 holds it, so a disabled transmitter holds its last level. With `nrziEn`=1 and `forceHigh`=1, the line is driven to 1 whatever `txEn` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| txEn | input | 1 | Transmit enable, sampled at unit boundaries |
| crcEn | input | 1 | Accumulate CRC over data and allow CRC ending |
| nrziEn | input | 1 | NRZI line coding |
| idleFlags | input | 1 | Idle with flags (1) or ones (0) |
| abortOnUnderrun | input | 1 | Underrun ending: abort (1) or CRC (0) |
| crcPresetOnes | input | 1 | CRC preset value: ones (1) or zeros (0) |
| autoOpenFlag | input | 1 | Automatic opening flag and CRC preset |
| autoEomClear | input | 1 | Clear the end-of-message latch at frame start |
| forceHigh | input | 1 | Drive line high while NRZI is on |
| eomClear | input | 1 | One-cycle command clearing the latch |
| wrStrobe | input | 1 | Write the holding buffer |
| wrData | input | 8 | Byte to write |
| bufEmpty | output | 1 | Holding buffer can take a byte |
| eomLatch | output | 1 | End-of-message latch |
| txOut | output | 1 | Serial line output |

## Verification
`txOut` is a combinational view of the current unit bit and the NRZI level register, so a bit is due in the same cycle it becomes current. A unit chosen at a boundary edge shows its first bit in the very next cycle. `bufEmpty` and `eomLatch` respond one cycle after the edge that wrote, loaded or set them. The bench advances a queue-based line model on each rising edge. It drives inputs just after each falling edge and compares all three outputs at the following falling edge, so every expected value lines up with the cycle in which that output is due.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  // kind of eight-bit unit placed into the shifter at a boundary
  typedef enum logic [2:0] {
    U_ONES  = 3'd0,
    U_FLAG  = 3'd1,
    U_DATA  = 3'd2,
    U_CRCLO = 3'd3,
    U_CRCHI = 3'd4
  } unit_e;

  // frame sequencing state: what the next boundary decides
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_CRCHI = 2'd2,
    ST_CLOSE = 2'd3
  } tx_state_e;

  // strobes from control to datapath, meaningful at a boundary
  typedef struct packed {
    unit_e unitSel;
    logic  presetCrc;
    logic  accumCrc;
  } tx_strobe_t;

endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              boundary,
  input  logic              txEn,
  input  logic              crcEn,
  input  logic              idleFlags,
  input  logic              abortOnUnderrun,
  input  logic              autoOpenFlag,
  input  logic              autoEomClear,
  input  logic              eomClear,
  input  logic              wrStrobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic              bufEmpty,
  output logic [BYTE_W-1:0] bufData,
  output logic              eomLatch,
  output tx_strobe_t        strobe
);

  tx_state_e state, stateNext;
  logic bufFull;
  logic prevFlag;
  logic consume;
  logic eomSet;
  logic frameStart;
  logic wrTake;

  assign bufEmpty = !bufFull;
  assign wrTake   = wrStrobe && !bufFull;

  // boundary decision: pick the next unit and advance the sequence
  always_comb begin
    strobe     = '{unitSel: U_ONES, presetCrc: 1'b0, accumCrc: 1'b0};
    stateNext  = state;
    consume    = 1'b0;
    eomSet     = 1'b0;
    frameStart = 1'b0;
    if (boundary) begin
      if (!txEn) begin
        stateNext = ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (bufFull) begin
              frameStart       = 1'b1;
              stateNext        = ST_FRAME;
              strobe.presetCrc = autoOpenFlag;
              if (autoOpenFlag && !prevFlag) begin
                strobe.unitSel = U_FLAG;
              end else begin
                strobe.unitSel  = U_DATA;
                strobe.accumCrc = crcEn;
                consume         = 1'b1;
              end
            end else begin
              strobe.unitSel = idleFlags ? U_FLAG : U_ONES;
            end
          end
          ST_FRAME: begin
            if (bufFull) begin
              strobe.unitSel  = U_DATA;
              strobe.accumCrc = crcEn;
              consume         = 1'b1;
            end else if (eomLatch) begin
              strobe.unitSel = U_FLAG;
              stateNext      = ST_IDLE;
            end else if (abortOnUnderrun) begin
              strobe.unitSel = U_ONES;
              eomSet         = 1'b1;
              stateNext      = ST_CLOSE;
            end else if (crcEn) begin
              strobe.unitSel = U_CRCLO;
              eomSet         = 1'b1;
              stateNext      = ST_CRCHI;
            end else begin
              strobe.unitSel = U_FLAG;
              stateNext      = ST_IDLE;
            end
          end
          ST_CRCHI: begin
            strobe.unitSel = U_CRCHI;
            stateNext      = ST_CLOSE;
          end
          default: begin
            strobe.unitSel = U_FLAG;
            stateNext      = ST_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bufFull  <= 1'b0;
      bufData  <= '0;
      prevFlag <= 1'b0;
      eomLatch <= 1'b1;
    end else begin
      state <= stateNext;
      if (consume) begin
        bufFull <= 1'b0;
      end else if (wrTake) begin
        bufFull <= 1'b1;
      end
      if (wrTake) begin
        bufData <= wrData;
      end
      if (boundary) begin
        prevFlag <= (strobe.unitSel == U_FLAG);
      end
      if (eomSet) begin
        eomLatch <= 1'b1;
      end else if (eomClear || (frameStart && autoEomClear)) begin
        eomLatch <= 1'b0;
      end
    end
  end

  a_r1_write_taken: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && bufEmpty) |=> !bufEmpty);

  a_r1_full_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !bufEmpty) |=> $stable(bufData));

  a_r7_latch_sets_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eomLatch) |-> $past(boundary));

  a_r11_disabled_drops_frame: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !txEn) |=> (state == ST_IDLE));

endmodule

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
#(
  parameter int                  BYTE_W    = 8,
  parameter int                  STUFF_RUN = 5,
  parameter logic [BYTE_W-1:0]   FLAG_PAT  = 8'h7E,
  parameter logic [2*BYTE_W-1:0] CRC_POLY  = 16'h8408
) (
  input  logic              clk,
  input  logic              rstN,
  input  tx_strobe_t        strobe,
  input  logic [BYTE_W-1:0] bufData,
  input  logic              nrziEn,
  input  logic              forceHigh,
  input  logic              crcPresetOnes,
  output logic              boundary,
  output logic              txOut
);

  localparam int CRC_W = 2 * BYTE_W;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STUFF_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              stuffMode;
  logic              stuffNow;
  logic [RUN_W-1:0]  onesCnt;
  logic [RUN_W-1:0]  onesNext;
  logic              lvl;
  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  crcBase;
  logic [CRC_W-1:0]  crcNext;
  logic [BYTE_W-1:0] loadByte;
  logic              loadStuffed;
  logic              rawBit;
  logic              stuffHit;
  logic              lineRaw;
  logic              pastValid;

  function automatic logic [CRC_W-1:0] crcAccum(input logic [CRC_W-1:0] seed,
                                                input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] c;
    logic fb;
    c = seed;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  // current line bit and unit-end detection
  assign rawBit   = stuffNow ? 1'b0 : shReg[0];
  assign stuffHit = !stuffNow && stuffMode && shReg[0] && (onesCnt == RUN_LAST);
  assign boundary = stuffNow ? (bitCnt == '0) : ((bitCnt == ONE_CNT) && !stuffHit);
  assign onesNext = (stuffNow || !stuffMode || !shReg[0]) ? '0 : onesCnt + RUN_ONE;

  // line coding
  assign lineRaw = nrziEn ? (rawBit ? lvl : !lvl) : rawBit;
  assign txOut   = (nrziEn && forceHigh) ? 1'b1 : lineRaw;

  // CRC arithmetic
  assign crcBase = strobe.presetCrc ? {CRC_W{crcPresetOnes}} : crcReg;
  assign crcNext = crcAccum(crcBase, bufData);

  // unit selection into the shifter
  always_comb begin
    loadStuffed = 1'b0;
    case (strobe.unitSel)
      U_FLAG:  loadByte = FLAG_PAT;
      U_DATA:  begin loadByte = bufData;                 loadStuffed = 1'b1; end
      U_CRCLO: begin loadByte = ~crcReg[BYTE_W-1:0];     loadStuffed = 1'b1; end
      U_CRCHI: begin loadByte = ~crcReg[CRC_W-1:BYTE_W]; loadStuffed = 1'b1; end
      default: loadByte = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '1;
      bitCnt    <= FULL_CNT;
      stuffMode <= 1'b0;
      stuffNow  <= 1'b0;
      onesCnt   <= '0;
      lvl       <= 1'b1;
      crcReg    <= '1;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      lvl       <= lineRaw;
      if (boundary) begin
        shReg     <= loadByte;
        bitCnt    <= FULL_CNT;
        stuffMode <= loadStuffed;
        stuffNow  <= 1'b0;
        onesCnt   <= loadStuffed ? onesNext : '0;
        if (strobe.accumCrc) begin
          crcReg <= crcNext;
        end else if (strobe.presetCrc) begin
          crcReg <= crcBase;
        end
      end else if (stuffNow) begin
        stuffNow <= 1'b0;
        onesCnt  <= '0;
      end else begin
        shReg    <= shReg >> 1;
        bitCnt   <= bitCnt - ONE_CNT;
        onesCnt  <= onesNext;
        stuffNow <= stuffHit;
      end
    end
  end

  a_r3_unstuffed_no_run: assert property (@(posedge clk) disable iff (!rstN)
    !stuffMode |-> (onesCnt == '0));

  a_r3_stuff_after_run: assert property (@(posedge clk) disable iff (!rstN)
    stuffNow |-> (rawBit == 1'b0) && $past(shReg[0]) && $past(stuffMode));

  a_r12_nrzi_one_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && nrziEn && !forceHigh && $past(nrziEn) && !$past(forceHigh) && rawBit)
      |-> (txOut == $past(txOut)));

  a_r12_force_high: assert property (@(posedge clk) disable iff (!rstN)
    (nrziEn && forceHigh) |-> txOut);

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int                  BYTE_W    = 8,
  parameter int                  STUFF_RUN = 5,
  parameter logic [BYTE_W-1:0]   FLAG_PAT  = 8'h7E,
  parameter logic [2*BYTE_W-1:0] CRC_POLY  = 16'h8408
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEn,
  input  logic              crcEn,
  input  logic              nrziEn,
  input  logic              idleFlags,
  input  logic              abortOnUnderrun,
  input  logic              crcPresetOnes,
  input  logic              autoOpenFlag,
  input  logic              autoEomClear,
  input  logic              forceHigh,
  input  logic              eomClear,
  input  logic              wrStrobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic              bufEmpty,
  output logic              eomLatch,
  output logic              txOut
);

  tx_strobe_t        strobe;
  logic              boundary;
  logic [BYTE_W-1:0] bufData;

  hdlc_tx_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk             (clk),
    .rstN            (rstN),
    .boundary        (boundary),
    .txEn            (txEn),
    .crcEn           (crcEn),
    .idleFlags       (idleFlags),
    .abortOnUnderrun (abortOnUnderrun),
    .autoOpenFlag    (autoOpenFlag),
    .autoEomClear    (autoEomClear),
    .eomClear        (eomClear),
    .wrStrobe        (wrStrobe),
    .wrData          (wrData),
    .bufEmpty        (bufEmpty),
    .bufData         (bufData),
    .eomLatch        (eomLatch),
    .strobe          (strobe)
  );

  hdlc_tx_dp #(
    .BYTE_W    (BYTE_W),
    .STUFF_RUN (STUFF_RUN),
    .FLAG_PAT  (FLAG_PAT),
    .CRC_POLY  (CRC_POLY)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .bufData       (bufData),
    .nrziEn        (nrziEn),
    .forceHigh     (forceHigh),
    .crcPresetOnes (crcPresetOnes),
    .boundary      (boundary),
    .txOut         (txOut)
  );

endmodule

// File: tb/hdlc_tx_tb_top.sv
module hdlc_tx_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0;
  logic       txEn = 1'b1, crcEn = 1'b1, nrziEn = 1'b0, idleFlags = 1'b0;
  logic       abortOnUnderrun = 1'b0, crcPresetOnes = 1'b1, autoOpenFlag = 1'b1;
  logic       autoEomClear = 1'b1, forceHigh = 1'b0, eomClear = 1'b0, wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       bufEmpty, eomLatch, txOut;

  hdlc_tx dut_i (
    .clk(clk), .rstN(rstN), .txEn(txEn), .crcEn(crcEn), .nrziEn(nrziEn),
    .idleFlags(idleFlags), .abortOnUnderrun(abortOnUnderrun),
    .crcPresetOnes(crcPresetOnes), .autoOpenFlag(autoOpenFlag),
    .autoEomClear(autoEomClear), .forceHigh(forceHigh), .eomClear(eomClear),
    .wrStrobe(wrStrobe), .wrData(wrData), .bufEmpty(bufEmpty),
    .eomLatch(eomLatch), .txOut(txOut)
  );

  int    nChecks = 0;
  int    nBad = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string curReq = "R4";

  // ---------------- behavioural line model ----------------
  bit        mQ[$];
  int        mState;      // 0 idle, 1 in frame, 2 crc high next, 3 closing flag next
  bit        mBufFull;
  logic [7:0] mBufData;
  bit        mEom;
  bit        mPrevFlag;
  logic [15:0] mCrc;
  int        mRun;
  bit        mLvl;
  bit        mSetNow;
  bit        mHead;
  bit        mLine;
  bit        mOldFull;

  function automatic logic [15:0] refCrc(logic [15:0] c, logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function void pushUnit(logic [7:0] b, bit stuffed);
    for (int i = 0; i < 8; i++) begin
      mQ.push_back(b[i]);
      if (stuffed) begin
        if (b[i]) begin
          mRun++;
          if (mRun == 5) begin mQ.push_back(1'b0); mRun = 0; end
        end else mRun = 0;
      end
    end
    if (!stuffed) mRun = 0;
  endfunction

  function void modelReset();
    mQ.delete();
    for (int i = 0; i < 8; i++) mQ.push_back(1'b1);
    mState = 0; mBufFull = 0; mBufData = 0; mEom = 1; mPrevFlag = 0;
    mCrc = 16'hFFFF; mRun = 0; mLvl = 1;
  endfunction

  function void takeData(output logic [7:0] b);
    b = mBufData;
    mBufFull = 0;
    if (crcEn) mCrc = refCrc(mCrc, b);
  endfunction

  function void modelBoundary();
    logic [7:0] b;
    bit stf;
    b = 8'hFF; stf = 0;
    if (!txEn) begin
      mState = 0;
    end else begin
      case (mState)
        0: if (mBufFull) begin
             if (autoEomClear) mEom = 0;
             if (autoOpenFlag) mCrc = crcPresetOnes ? 16'hFFFF : 16'h0000;
             mState = 1;
             if (autoOpenFlag && !mPrevFlag) b = 8'h7E;
             else begin takeData(b); stf = 1; end
           end else b = idleFlags ? 8'h7E : 8'hFF;
        1: if (mBufFull) begin takeData(b); stf = 1; end
           else if (mEom) begin b = 8'h7E; mState = 0; end
           else if (abortOnUnderrun) begin b = 8'hFF; mEom = 1; mSetNow = 1; mState = 3; end
           else if (crcEn) begin b = ~mCrc[7:0]; stf = 1; mEom = 1; mSetNow = 1; mState = 2; end
           else begin b = 8'h7E; mState = 0; end
        2: begin b = ~mCrc[15:8]; stf = 1; mState = 3; end
        default: begin b = 8'h7E; mState = 0; end
      endcase
    end
    mPrevFlag = (b == 8'h7E) && !stf;
    pushUnit(b, stf);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) modelReset();
    else begin
      mSetNow  = 0;
      mOldFull = mBufFull;
      mHead    = mQ[0];
      mLine    = nrziEn ? (mHead ? mLvl : ~mLvl) : mHead;
      mLvl     = mLine;
      void'(mQ.pop_front());
      if (mQ.size() == 0) modelBoundary();
      if (eomClear && !mSetNow) mEom = 0;
      if (wrStrobe && !mOldFull) begin mBufFull = 1; mBufData = wrData; end
    end
  end

  // ---------------- checking ----------------
  function void check(string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", curReq, what, act, exp, $time);
    end
  endfunction

  function void check16(string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (rstN && !done) begin
      mHead = mQ[0];
      mLine = nrziEn ? (mHead ? mLvl : ~mLvl) : mHead;
      check("txOut", txOut, (nrziEn && forceHigh) ? 1'b1 : mLine);
      check("bufEmpty", bufEmpty, !mBufFull);
      check("eomLatch", eomLatch, mEom);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      nChecks++; nBad++;
      $display("FAIL %s watchdog actual=%0d expected<=20000 cycles", curReq, cyc);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic waitCycles(int n);
    repeat (n) tick();
  endtask

  task automatic sendByte(logic [7:0] b);
    tick();
    while (!bufEmpty) tick();
    wrStrobe = 1'b1; wrData = b;
    tick();
    wrStrobe = 1'b0;
  endtask

  task automatic pulseClear();
    eomClear = 1'b1; tick(); eomClear = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // reset state, checked while reset is held
    curReq = "R1";  check("reset bufEmpty", bufEmpty, 1'b1);
    curReq = "R10"; check("reset eomLatch", eomLatch, 1'b1);
    curReq = "R4";  check("reset txOut", txOut, 1'b1);
    #1 rstN = 1'b1;

    // R6: reference CRC sanity, standard check string
    begin
      logic [15:0] c = 16'hFFFF;
      string s = "123456789";
      for (int i = 0; i < s.len(); i++) c = refCrc(c, s[i]);
      curReq = "R6";
      check16("check-string FCS", ~c, 16'h906E);
    end

    curReq = "R4";  waitCycles(20);
    idleFlags = 1'b1; waitCycles(24); idleFlags = 1'b0; waitCycles(16);

    // R2 R7: frame with CRC ending, latch auto-cleared at start
    curReq = "R2 R7";
    sendByte(8'h12); sendByte(8'hFF); sendByte(8'h7E); sendByte(8'hF8);
    waitCycles(70);

    // R3: long runs of ones crossing byte boundaries
    curReq = "R3";
    sendByte(8'hFF); sendByte(8'hFF); sendByte(8'h3E);
    waitCycles(70);

    // R9: latch left set, frame closes with flag only
    autoEomClear = 1'b0; curReq = "R9";
    sendByte(8'h55); sendByte(8'hA5);
    waitCycles(60);

    // R10 clear command, then R8 abort ending
    curReq = "R10"; pulseClear(); waitCycles(5);
    abortOnUnderrun = 1'b1; curReq = "R8";
    sendByte(8'h0F); sendByte(8'hF0);
    waitCycles(60);
    abortOnUnderrun = 1'b0;

    // R5: no automatic opening flag from mark idle
    curReq = "R5"; pulseClear(); autoOpenFlag = 1'b0;
    sendByte(8'h81); sendByte(8'h42);
    waitCycles(60);
    autoOpenFlag = 1'b1;

    // R6: zero preset
    autoEomClear = 1'b1; crcPresetOnes = 1'b0; curReq = "R6";
    sendByte(8'h01); sendByte(8'h80);
    waitCycles(60);
    crcPresetOnes = 1'b1;

    // R5: data straight after idle flags
    idleFlags = 1'b1; curReq = "R5";
    waitCycles(12);
    sendByte(8'h3C);
    waitCycles(50);
    idleFlags = 1'b0; waitCycles(20);

    // R1: second write while full is ignored
    curReq = "R1";
    wrStrobe = 1'b1; wrData = 8'hAA; tick();
    wrData = 8'hBB; tick();
    wrStrobe = 1'b0;
    waitCycles(60);

    // R11: disable during opening flag keeps the buffered byte
    curReq = "R11";
    sendByte(8'hC3);
    waitCycles(3); txEn = 1'b0;
    waitCycles(30);
    txEn = 1'b1;
    waitCycles(60);

    // R9: CRC disabled, latch clear, flag-only ending leaves latch clear
    crcEn = 1'b0; curReq = "R9";
    sendByte(8'h11);
    waitCycles(50);
    crcEn = 1'b1;

    // R12: NRZI frame, disabled hold, force high
    nrziEn = 1'b1; curReq = "R12";
    sendByte(8'h6B); sendByte(8'h00);
    waitCycles(60);
    txEn = 1'b0; waitCycles(20);
    forceHigh = 1'b1; waitCycles(20);
    forceHigh = 1'b0; txEn = 1'b1; waitCycles(20);
    nrziEn = 1'b0; waitCycles(20);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule